// File: doc/BRIEF.md
# Integer ALU with Divide-by-Zero Flag

This block is the purely combinational arithmetic-logic unit of a small processor that moves data over a single shared bus. It takes two 32-bit operands and a 4-bit operation code. It returns a 64-bit result, so that products and quotients can be written into a separate high/low register pair. Operations that produce a single word leave that word in the low half and clear the high half.

Addition, subtraction and negation all pass through one shared adder-subtractor. Shifts and rotates run through a logarithmic barrel. Signed division runs through a restoring array of subtract stages. Multiplication is computed by a separate multiplier, and its 64-bit product only passes through this block. A divide whose divisor is zero raises a flag and produces an all-zero result. Any exception handling is left to the surrounding control logic.

Top module: `alu_core`

## Requirements
- R1: Code 0 gives the bitwise AND of both operands, code 1 the bitwise OR, and code 11 the bitwise complement of the first operand.
- R2: Code 2 gives the sum and code 3 the difference (first minus second), both taken modulo 2^32.
- R3: Code 10 gives the two's complement of the first operand. Zero stays zero, and 0x80000000 maps to itself.
- R4: Code 6 shifts the first operand right by the amount in bits [4:0] of the second operand, and the vacated high bits are filled with zeros.
- R5: Code 7 shifts the first operand left by that same 5-bit amount, and the vacated low bits are filled with zeros.
- R6: Code 8 rotates the first operand right and code 9 rotates it left, by that same 5-bit amount. An amount of zero, for example a second operand of 32, returns the operand unchanged.
- R7: Code 4 copies the 64-bit external product input to the result without change.
- R8: Code 5 performs a signed divide. Result bits [31:0] hold the quotient, truncated toward zero. Bits [63:32] hold the remainder, which takes the sign of the dividend. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R9: The divide-by-zero output is high exactly when the code is 5 and the second operand is zero. When it is high, all 64 result bits are zero.
- R10: For every code other than 4 and 5, result bits [63:32] are zero.
- R11: Codes 12 to 15 give an all-zero result with the flag low, and the product input has no effect on them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand: dividend, shift source, negate source |
| opnd_b | input | 32 | Second operand: divisor, shift or rotate amount in bits [4:0] |
| op_sel | input | 4 | Operation code |
| mul_prod | input | 64 | Product from the external multiplier |
| result | output | 64 | High and low result words |
| div_by_zero | output | 1 | Divide attempted with a zero divisor |

## Verification
The sign corners of the divider are hard to reach with uniform random operands. These are the most negative dividend over -1, remainders that must carry a negative dividend's sign, and divisors larger than the dividend. The stimulus therefore mixes full-width random values with divisors drawn from a small signed range and with directed cases for each sign combination. The divide-by-zero path almost never appears at random, so it is also forced directly. Shift and rotate amounts are drawn so that 0, 31 and values with upper bits set in the second operand all occur.

// File: rtl/alu_pkg.sv
package alu_pkg;

    parameter int unsigned XLEN   = 32;
    localparam int unsigned AMT_W = $clog2(XLEN);
    localparam int unsigned RES_W = 2 * XLEN;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,
        OP_OR  = 4'd1,
        OP_ADD = 4'd2,
        OP_SUB = 4'd3,
        OP_MUL = 4'd4,
        OP_DIV = 4'd5,
        OP_SHR = 4'd6,
        OP_SHL = 4'd7,
        OP_ROR = 4'd8,
        OP_ROL = 4'd9,
        OP_NEG = 4'd10,
        OP_NOT = 4'd11
    } alu_op_e;

    typedef enum logic [1:0] {
        MV_SHR = 2'd0,
        MV_SHL = 2'd1,
        MV_ROR = 2'd2,
        MV_ROL = 2'd3
    } move_kind_e;

    typedef struct packed {
        logic [XLEN-1:0] hi;
        logic [XLEN-1:0] lo;
    } wide_res_t;

    function automatic logic is_known_op(logic [3:0] code);
        return code <= 4'd11;
    endfunction

    function automatic logic is_wide_op(logic [3:0] code);
        return (code == OP_MUL) || (code == OP_DIV);
    endfunction

    function automatic logic [XLEN-1:0] magnitude(logic [XLEN-1:0] v);
        return v[XLEN-1] ? (~v + 1'b1) : v;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] y_eff;
    logic [W-1:0] cin_vec;

    assign y_eff   = y_in ^ {W{sub}};
    assign cin_vec = {{(W-1){1'b0}}, sub};
    assign sum     = x_in + y_eff + cin_vec;

    always_comb begin
        if (!$isunknown({x_in, y_in, sub})) begin
            assert_addsub_inverse_R2: assert ((sub ? (sum + y_in) : (sum - y_in)) == x_in)
                else $error("adder-subtractor result does not invert");
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int unsigned W = 32,
    localparam int unsigned SW = $clog2(W)
) (
    input  logic [W-1:0]          data_in,
    input  logic [SW-1:0]         amount,
    input  alu_pkg::move_kind_e   kind,
    output logic [W-1:0]          data_out
);
    import alu_pkg::*;

    logic [W-1:0] stage [SW+1];

    assign stage[0] = data_in;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int unsigned D = 1 << k;
        logic [W-1:0] moved;
        always_comb begin
            unique case (kind)
                MV_SHR:  moved = {{D{1'b0}}, stage[k][W-1:D]};
                MV_SHL:  moved = {stage[k][W-D-1:0], {D{1'b0}}};
                MV_ROR:  moved = {stage[k][D-1:0], stage[k][W-1:D]};
                default: moved = {stage[k][W-D-1:0], stage[k][W-1:W-D]};
            endcase
        end
        assign stage[k+1] = amount[k] ? moved : stage[k];
    end

    assign data_out = stage[SW];

    always_comb begin
        if (!$isunknown({data_in, amount, kind})) begin
            if (kind == MV_ROR || kind == MV_ROL)
                assert_rotate_keeps_ones_R6: assert ($countones(data_out) == $countones(data_in))
                    else $error("rotate changed population count");
            if (kind == MV_SHR && amount != '0)
                assert_shr_zero_fill_R4: assert (data_out[W-1] == 1'b0)
                    else $error("logical right shift filled a one");
        end
    end
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         zero_div
);
    import alu_pkg::*;

    logic [W-1:0] mag_n;
    logic [W-1:0] mag_d;
    logic [W-1:0] uq;
    logic [W-1:0] part [W+1];

    assign mag_n   = magnitude(dividend);
    assign mag_d   = magnitude(divisor);
    assign zero_div = (divisor == '0);
    assign part[0] = '0;

    // Restoring array: each row brings down one dividend bit, MSB first.
    for (genvar i = 0; i < W; i++) begin : g_row
        localparam int unsigned BIT = W - 1 - i;
        logic         carry_hi;
        logic [W-1:0] shifted;
        logic [W-1:0] diff;
        logic         fits;
        assign carry_hi = part[i][W-1];
        assign shifted  = {part[i][W-2:0], mag_n[BIT]};
        assign diff     = shifted - mag_d;
        assign fits     = carry_hi | (shifted >= mag_d);
        assign uq[BIT]  = fits;
        assign part[i+1] = fits ? diff : shifted;
    end

    assign quotient  = (dividend[W-1] ^ divisor[W-1]) ? (~uq + 1'b1) : uq;
    assign remainder = dividend[W-1] ? (~part[W] + 1'b1) : part[W];

    always_comb begin
        if (!$isunknown({dividend, divisor}) && !zero_div) begin
            assert_div_recombine_R8: assert ((quotient * divisor + remainder) == dividend)
                else $error("quotient and remainder do not recombine");
            assert_rem_sign_R8: assert (remainder == '0 || remainder[W-1] == dividend[W-1])
                else $error("remainder sign differs from dividend");
            assert_rem_bound_R8: assert (magnitude(remainder) < mag_d || mag_d == '0)
                else $error("remainder not below divisor");
        end
    end
endmodule

// File: rtl/alu_core.sv
module alu_core (
    input  logic [alu_pkg::XLEN-1:0]  opnd_a,
    input  logic [alu_pkg::XLEN-1:0]  opnd_b,
    input  logic [3:0]                op_sel,
    input  logic [alu_pkg::RES_W-1:0] mul_prod,
    output logic [alu_pkg::RES_W-1:0] result,
    output logic                      div_by_zero
);
    import alu_pkg::*;

    alu_op_e         op;
    logic [XLEN-1:0] as_x;
    logic [XLEN-1:0] as_y;
    logic            as_sub;
    logic [XLEN-1:0] as_sum;
    move_kind_e      mv_kind;
    logic [XLEN-1:0] mv_out;
    logic [XLEN-1:0] dv_q;
    logic [XLEN-1:0] dv_r;
    logic            dv_zero;
    wide_res_t       res;

    assign op = alu_op_e'(op_sel);

    // Negate reuses the subtractor as 0 - a.
    always_comb begin
        as_x   = opnd_a;
        as_y   = opnd_b;
        as_sub = 1'b0;
        if (op_sel == OP_SUB) begin
            as_sub = 1'b1;
        end else if (op_sel == OP_NEG) begin
            as_x   = '0;
            as_y   = opnd_a;
            as_sub = 1'b1;
        end
    end

    always_comb begin
        unique case (op_sel)
            OP_SHL:  mv_kind = MV_SHL;
            OP_ROR:  mv_kind = MV_ROR;
            OP_ROL:  mv_kind = MV_ROL;
            default: mv_kind = MV_SHR;
        endcase
    end

    alu_addsub #(.W(XLEN)) u_addsub (
        .x_in (as_x),
        .y_in (as_y),
        .sub  (as_sub),
        .sum  (as_sum)
    );

    alu_shifter #(.W(XLEN)) u_shifter (
        .data_in  (opnd_a),
        .amount   (opnd_b[AMT_W-1:0]),
        .kind     (mv_kind),
        .data_out (mv_out)
    );

    alu_divider #(.W(XLEN)) u_divider (
        .dividend  (opnd_a),
        .divisor   (opnd_b),
        .quotient  (dv_q),
        .remainder (dv_r),
        .zero_div  (dv_zero)
    );

    always_comb begin
        res = '0;
        if (is_known_op(op_sel)) begin
            unique case (op)
                OP_AND: res.lo = opnd_a & opnd_b;
                OP_OR:  res.lo = opnd_a | opnd_b;
                OP_NOT: res.lo = ~opnd_a;
                OP_ADD, OP_SUB, OP_NEG: res.lo = as_sum;
                OP_SHR, OP_SHL, OP_ROR, OP_ROL: res.lo = mv_out;
                OP_MUL: res = mul_prod;
                OP_DIV: begin
                    if (!dv_zero) begin
                        res.hi = dv_r;
                        res.lo = dv_q;
                    end
                end
                default: res = '0;
            endcase
        end
    end

    assign result      = res;
    assign div_by_zero = (op_sel == OP_DIV) && dv_zero;

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel, mul_prod})) begin
            if (div_by_zero)
                assert_dbz_clears_R9: assert (result == '0)
                    else $error("divide by zero left a nonzero result");
            if (!is_wide_op(op_sel))
                assert_narrow_hi_zero_R10: assert (result[RES_W-1:XLEN] == '0)
                    else $error("single-word op drove the high half");
            if (!is_known_op(op_sel))
                assert_unused_code_R11: assert (result == '0 && !div_by_zero)
                    else $error("unused code produced output");
            if (op_sel == OP_MUL)
                assert_mul_route_R7: assert (result == mul_prod)
                    else $error("product not routed");
        end
    end
endmodule

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;
    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_sel = '0;
    logic [63:0] mul_prod = '0;
    logic [63:0] result;
    logic        div_by_zero;
    int          checks = 0;
    int          bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    alu_core dut_i (
        .opnd_a      (opnd_a),
        .opnd_b      (opnd_b),
        .op_sel      (op_sel),
        .mul_prod    (mul_prod),
        .result      (result),
        .div_by_zero (div_by_zero)
    );

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1, 4'd11: return "R1";
            4'd2, 4'd3:        return "R2";
            4'd10:             return "R3";
            4'd6:              return "R4";
            4'd7:              return "R5";
            4'd8, 4'd9:        return "R6";
            4'd4:              return "R7";
            4'd5:              return "R8/R9";
            default:           return "R11";
        endcase
    endfunction

    function automatic logic [64:0] model(logic [31:0] a, logic [31:0] b,
                                          logic [3:0] op, logic [63:0] mp);
        logic [31:0] r;
        int s;
        longint sa, sb, q, m;
        r = '0;
        s = int'(b[4:0]);
        case (op)
            4'd0:  r = a & b;
            4'd1:  r = a | b;
            4'd11: r = ~a;
            4'd2:  r = a + b;
            4'd3:  r = a - b;
            4'd10: r = 32'd0 - a;
            4'd6:  r = a >> s;
            4'd7:  r = a << s;
            4'd8:  for (int i = 0; i < 32; i++) r[i] = a[(i + s) % 32];
            4'd9:  for (int i = 0; i < 32; i++) r[i] = a[(i - s + 32) % 32];
            4'd4:  return {1'b0, mp};
            4'd5: begin
                if (b == 32'd0) return {1'b1, 64'd0};
                sa = longint'($signed(a));
                sb = longint'($signed(b));
                q = sa / sb;
                m = sa % sb;
                return {1'b0, m[31:0], q[31:0]};
            end
            default: r = '0;
        endcase
        return {1'b0, 32'd0, r};
    endfunction

    task automatic apply(logic [31:0] a, logic [31:0] b, logic [3:0] op, logic [63:0] mp);
        logic [64:0] exp_v;
        @(posedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; mul_prod = mp;
        #2;
        exp_v = model(a, b, op, mp);
        checks++;
        if ({div_by_zero, result} !== exp_v) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h actual flag=%b res=%h expected flag=%b res=%h",
                     tag_of(op), op, a, b, div_by_zero, result, exp_v[64], exp_v[63:0]);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb;
        logic [63:0] rm;
        void'($urandom(32'd20240607));
        // Idle state with all inputs zero (R1)
        apply(32'd0, 32'd0, 4'd0, 64'd0);
        // R3 negate corners
        apply(32'd0, 32'h1234, 4'd10, 64'd0);
        apply(32'h8000_0000, 32'd0, 4'd10, 64'd0);
        // R4 R5 R6 amount corners
        apply(32'h8000_0001, 32'd31, 4'd6, 64'd0);
        apply(32'h8000_0001, 32'd31, 4'd7, 64'd0);
        apply(32'hDEAD_BEEF, 32'd32, 4'd8, 64'd0);
        apply(32'hDEAD_BEEF, 32'd0, 4'd9, 64'd0);
        apply(32'hF000_000F, 32'hFFFF_FFE4, 4'd8, 64'd0);
        // R7 product passthrough
        apply(32'd5, 32'd7, 4'd4, 64'hCAFE_F00D_1234_5678);
        // R8 sign cases and overflow corner
        apply(32'hFFFF_FFF9, 32'd2, 4'd5, 64'd0);
        apply(32'd7, 32'hFFFF_FFFE, 4'd5, 64'd0);
        apply(32'hFFFF_FFF9, 32'hFFFF_FFFE, 4'd5, 64'd0);
        apply(32'h8000_0000, 32'hFFFF_FFFF, 4'd5, 64'd0);
        apply(32'd3, 32'd100, 4'd5, 64'd0);
        // R9 divide by zero
        apply(32'h7FFF_FFFF, 32'd0, 4'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        apply(32'h8000_0000, 32'd0, 4'd5, 64'd0);
        // R11 unused codes with a live product input
        for (int c = 12; c < 16; c++)
            apply(32'hFFFF_FFFF, 32'd0, 4'(c), 64'hFFFF_FFFF_FFFF_FFFF);
        // Random sweep over all codes (R1..R11, R10 via high-half compare)
        for (int n = 0; n < 4000; n++) begin
            ra = $urandom;
            rb = $urandom;
            rm = {$urandom, $urandom};
            case ($urandom_range(0, 3))
                0: rb = 32'($signed($urandom_range(0, 16)) - 8);
                1: ra = 32'($signed($urandom_range(0, 200)) - 100);
                default: ;
            endcase
            apply(ra, rb, 4'($urandom_range(0, 15)), rm);
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule